// File: doc/BRIEF.md
# Complementary Half-Bridge PWM Generator with Dead Band

This block drives the two switches of a half-bridge power stage from one shared timebase. The high-side drive, `out_a`, is active during the first part of each PWM period. The low-side drive, `out_b`, is active during the remainder of the period. Whenever either drive would become active, its rising edge is held back by a programmable number of clock cycles. This leaves a dead interval in which both switches are off, so current cannot shoot through the stage. Falling edges are never delayed.

Software sets the period length, the duty count and a 7-bit dead-band count. New duty and dead-band values are taken up only when a period ends, so a write in the middle of a period never produces a runt pulse. Deasserting the enable switches both drives off at once and returns the timebase to its starting point. When the enable is asserted again, output A's active phase starts afresh.

Top module: `hb_deadband_pwm`

## Requirements
- R1: After reset, with `en` low, `out_a` and `out_b` are both 0.
- R2: The timebase counts from 0 up to `period_i` inclusive, so successive rising edges of `out_a` are `period_i`+1 cycles apart.
- R3: Output A is nominally active while the count is below the duty value. With 0 < duty <= `period_i`, each `out_a` pulse lasts duty − dead cycles. Its fall follows the nominal fall without delay.
- R4: Output B is nominally active for the rest of the period. Each `out_b` pulse lasts (`period_i`+1−duty) − dead cycles.
- R5: `out_a` and `out_b` are never 1 in the same cycle.
- R6: With a dead-band value of 0, exactly one of `out_a` and `out_b` is 1 in every cycle of steady operation.
- R7: If the dead-band value is equal to or longer than an output's nominal active interval, that output stays 0 for the whole interval.
- R8: A duty of 0 keeps `out_a` at 0 and `out_b` continuously 1. A duty greater than `period_i` keeps `out_a` continuously 1 and `out_b` at 0, once the first dead band has elapsed.
- R9: Duty and dead-band values written during a period take effect only from the next period. The pulse that is already under way keeps its old length.
- R10: One cycle after `en` is seen low, both outputs are 0. After `en` rises, `out_a` first becomes 1 after dead+1 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces both drives off and clears the timebase |
| period_i | input | 8 | Terminal count of the timebase (period is this value + 1) |
| duty_i | input | 8 | Number of counts that output A is nominally active |
| dead_i | input | 7 | Dead-band hold-off in clock cycles |
| out_a | output | 1 | High-side drive, active high |
| out_b | output | 1 | Low-side drive, complementary, active high |

## Verification
Two events can fall in the same cycle here. In one, the dead-band hold-off runs out in exactly the cycle where the nominal phase ends. In the other, a new register write arrives while the period boundary is latching the shadow values. The first is provoked with dead equal to the active interval, which must give no pulse at all, and with dead one cycle shorter, which must give a one-cycle pulse. The second is provoked by rewriting duty and dead band just after an `out_a` rising edge. Both are judged by measured pulse lengths at the outputs: the current pulse must keep its old length and the next pulse must take the new one.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int HBP_CNT_W = 8;
  localparam int HBP_DB_W  = 7;
  typedef enum logic {CH_HI = 1'b0, CH_LO = 1'b1} hbp_chan_e;
endpackage

// File: rtl/hbp_timebase.sv
module hbp_timebase #(
  parameter int CNT_W = hbp_pkg::HBP_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;

  assign wrap = (cnt >= period);

  always_comb begin
    if (!en)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    en && wrap |=> cnt == '0); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && !wrap |=> cnt == $past(cnt) + 1'b1); // R2
endmodule

// File: rtl/hbp_shadow.sv
module hbp_shadow #(
  parameter int CNT_W = hbp_pkg::HBP_CNT_W,
  parameter int DB_W  = hbp_pkg::HBP_DB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wrap,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [DB_W-1:0]  dead_in,
  output logic [CNT_W-1:0] duty_s,
  output logic [DB_W-1:0]  dead_s
);
  logic             load;
  logic [CNT_W-1:0] duty_d;
  logic [DB_W-1:0]  dead_d;

  assign load = !en || wrap;

  always_comb begin
    duty_d = duty_s;
    dead_d = dead_s;
    if (load) begin
      duty_d = duty_in;
      dead_d = dead_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_s <= '0;
      dead_s <= '0;
    end else begin
      duty_s <= duty_d;
      dead_s <= dead_d;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && !wrap |=> $stable(duty_s) && $stable(dead_s)); // R9
endmodule

// File: rtl/hbp_deadband_ch.sv
module hbp_deadband_ch #(
  parameter int DB_W = hbp_pkg::HBP_DB_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            nom,
  input  logic [DB_W-1:0] dead,
  output logic            drive
);
  localparam logic [DB_W-1:0] RUN_MAX = '1;

  logic [DB_W-1:0] run, run_d;
  logic            drive_d;

  always_comb begin
    if (!en || !nom)        run_d = '0;
    else if (run == RUN_MAX) run_d = run;
    else                    run_d = run + 1'b1;
    drive_d = en && nom && (run >= dead);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      drive <= 1'b0;
    end else begin
      run   <= run_d;
      drive <= drive_d;
    end
  end

  AST_FALL_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    !nom |=> !drive); // R3
  AST_DB_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    en && $rose(nom) && (dead != '0) |=> !drive); // R7
endmodule

// File: rtl/hb_deadband_pwm.sv
module hb_deadband_pwm #(
  parameter int CNT_W = hbp_pkg::HBP_CNT_W,
  parameter int DB_W  = hbp_pkg::HBP_DB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DB_W-1:0]  dead_i,
  output logic             out_a,
  output logic             out_b
);
  localparam int NCH = 2;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CNT_W-1:0] duty_s;
  logic [DB_W-1:0]  dead_s;
  logic             a_phase;
  logic [NCH-1:0]   nom;
  logic [NCH-1:0]   drv;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  hbp_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_sn), .en(en), .period(period_i),
    .cnt(cnt), .wrap(wrap)
  );

  hbp_shadow #(.CNT_W(CNT_W), .DB_W(DB_W)) u_sh (
    .clk(clk), .rst_n(rst_sn), .en(en), .wrap(wrap),
    .duty_in(duty_i), .dead_in(dead_i),
    .duty_s(duty_s), .dead_s(dead_s)
  );

  assign a_phase = (cnt < duty_s);
  assign nom[hbp_pkg::CH_HI] = en && a_phase;
  assign nom[hbp_pkg::CH_LO] = en && !a_phase;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hbp_deadband_ch #(.DB_W(DB_W)) u_ch (
      .clk(clk), .rst_n(rst_sn), .en(en), .nom(nom[g]),
      .dead(dead_s), .drive(drv[g])
    );
  end

  assign out_a = drv[hbp_pkg::CH_HI];
  assign out_b = drv[hbp_pkg::CH_LO];

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_sn)
    !(out_a && out_b)); // R5
  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_sn)
    !en |=> !out_a && !out_b); // R10
endmodule

// File: tb/tb_hb_deadband_pwm.sv
module tb_hb_deadband_pwm;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] period_i;
  logic [7:0] duty_i;
  logic [6:0] dead_i;
  logic       out_a, out_b;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;

  hb_deadband_pwm dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period_i(period_i),
    .duty_i(duty_i), .dead_i(dead_i), .out_a(out_a), .out_b(out_b)
  );

  typedef struct packed { int p; int d; int db; int ea; int eb; } vec_t;
  localparam vec_t VEC [10] = '{
    '{9, 4, 1, 3, 5},      // R3 R4
    '{9, 4, 0, 4, 6},      // R6
    '{15, 8, 3, 5, 5},     // R3 R4
    '{7, 3, 3, 0, 2},      // R7 dead == interval
    '{7, 3, 6, 0, 0},      // R7 dead longer than both
    '{9, 0, 2, 0, 10},     // R8 duty 0
    '{9, 12, 2, 10, 0},    // R8 duty above period
    '{20, 19, 2, 17, 0},   // R7 on B
    '{20, 18, 2, 16, 1},   // R4 one-cycle B pulse
    '{30, 10, 127, 0, 0}   // R7 maximum dead band
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int p, input int d, input int db);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    period_i = 8'(p);
    duty_i   = 8'(d);
    dead_i   = 7'(db);
    en = 1'b1;
  endtask

  task automatic window(input int n, output int ca, output int cb,
                        output int ov, output int xr);
    ca = 0; cb = 0; ov = 0; xr = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ca += int'(out_a);
      cb += int'(out_b);
      ov += int'(out_a && out_b);
      xr += int'(out_a ^ out_b);
    end
  endtask

  task automatic wait_rise_a(output bit ok);
    int t;
    ok = 1'b0;
    t = 0;
    while (out_a && t < 2000) begin @(negedge clk); t++; end
    while (!out_a && t < 2000) begin @(negedge clk); t++; end
    ok = out_a;
  endtask

  task automatic pulse_a(output int len);
    bit ok;
    wait_rise_a(ok);
    len = 0;
    while (ok && out_a && len < 2000) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ca, cb, ov, xr, len, n;
    bit ok;
    rst_n = 1'b0; en = 1'b0;
    period_i = 8'd9; duty_i = 8'd4; dead_i = 7'd1;
    repeat (3) @(negedge clk);
    check(!out_a && !out_b, "R1 in reset", int'({out_a, out_b}), 0);
    rst_n = 1'b1;
    window(6, ca, cb, ov, xr);
    check(ca == 0 && cb == 0, "R1 idle after reset", ca + cb, 0);

    foreach (VEC[k]) begin
      setup(VEC[k].p, VEC[k].d, VEC[k].db);
      repeat (3 * (VEC[k].p + 1) + 140) @(negedge clk);
      window(VEC[k].p + 1, ca, cb, ov, xr);
      check(ca == VEC[k].ea, "R3/R7/R8 A active count", ca, VEC[k].ea);
      check(cb == VEC[k].eb, "R4/R7/R8 B active count", cb, VEC[k].eb);
      check(ov == 0, "R5 overlap", ov, 0);
      if (VEC[k].db == 0)
        check(xr == VEC[k].p + 1, "R6 exact complement", xr, VEC[k].p + 1);
      if (VEC[k].ea > 0 && VEC[k].ea < VEC[k].p + 1) begin
        wait_rise_a(ok);
        n = 0;
        @(negedge clk);
        wait_rise_a(ok);
        n = 0;
        while (out_a && n < 2000) begin n++; @(negedge clk); end
        while (!out_a && n < 2000) begin n++; @(negedge clk); end
        check(n == VEC[k].p + 1, "R2 period length", n, VEC[k].p + 1);
      end
    end

    // R9: rewrite duty and dead band just after a rising edge of out_a
    setup(19, 10, 2);
    repeat (60) @(negedge clk);
    wait_rise_a(ok);
    duty_i = 8'd15;
    dead_i = 7'd4;
    len = 0;
    while (out_a && len < 2000) begin len++; @(negedge clk); end
    check(len == 8, "R9 current pulse keeps old length", len, 8);
    pulse_a(len);
    check(len == 11, "R9 next pulse uses new values", len, 11);

    // R10: disable forces off, re-enable restarts with dead band
    setup(9, 4, 2);
    repeat (50) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!out_a && !out_b, "R10 off one cycle after disable", int'({out_a, out_b}), 0);
    window(12, ca, cb, ov, xr);
    check(ca + cb == 0, "R10 stays off while disabled", ca + cb, 0);
    en = 1'b1;
    n = 0;
    while (!out_a && n < 50) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check(n == 3, "R10 first A rise after dead+1 edges", n, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule